// File: doc/BRIEF.md
# Write-Back Direct-Mapped Data Cache

This block is a direct-mapped data cache placed between a simple processor request port and a slower lower-level memory. The processor presents one read or write at a time, using a byte address and a data word. The cache answers with a one-cycle ready pulse, a hit flag and, for reads, the requested word. Each line holds a valid bit, a dirty bit, a tag and a whole block of data. Writes that hit touch only the cached copy. A modified line travels to the lower level only when another block displaces it.

On the lower side, the cache moves whole blocks. It uses a request/acknowledge pair for victim write-backs and for block fills. It also issues single-word writes when a write miss goes around the cache. A static input picks the write-miss policy. In one setting the missing block is fetched and then written. In the other the write goes straight to memory and the cache is left untouched. Two counters tally hits and misses, so the policy's effect can be measured.

Top module: `wbcache`

## Requirements
- R1: After reset every line is invalid and clean, both counters read zero, `cpu_ready` is low and `mem_req` is low.
- R2: With the default sizes (32 lines of 32 bytes), address bits [4:0] select the byte, bits [4:2] select the word within the block, bits [9:5] select the line (block number modulo 32) and bits [31:10] form the tag.
- R3: A request hits only when the selected line is valid and its stored tag equals the address tag. A hit raises `cpu_ready` with `cpu_hit`=1 in the cycle after the request is accepted, and for a read it returns the stored word on `cpu_rdata`.
- R4: A write hit updates only the cached word and marks the line dirty, with no lower-level transaction.
- R5: A miss that will fill a line whose victim is valid and dirty first writes the whole victim block (`mem_we`=1, `mem_word`=0) at the victim's block-aligned address. A clean or invalid victim is dropped with no write-back.
- R6: A read miss fetches the block (`mem_we`=0) at the block-aligned address, installs it clean, and returns the addressed word from that block.
- R7: With `alloc_on_wmiss`=1, a write miss fills the block and then merges the written word into it, leaving the line valid and dirty.
- R8: With `alloc_on_wmiss`=0, a write miss issues one word write (`mem_we`=1, `mem_word`=1) at the full byte address, with the data in `mem_wdata[31:0]`, and leaves every line unchanged.
- R9: Each accepted request increments exactly one of `hit_count` (on a hit) and `miss_count` (on a miss).
- R10: `mem_req` stays high with stable address and kind until `mem_ack`. `cpu_ready` is a single-cycle pulse, after which the requester drops `cpu_req`.
- R11: Starting empty, writing byte 100, reading 200, writing 200 and writing 100 gives 2 hits and 2 misses with allocation, and 1 hit and 3 misses without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_on_wmiss | input | 1 | 1: allocate on write miss; 0: write around |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request hit, valid with `cpu_ready` |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| hit_count | output | 16 | Number of hits since reset |
| miss_count | output | 16 | Number of misses since reset |
| mem_req | output | 1 | Lower-level request |
| mem_we | output | 1 | Lower-level write |
| mem_word | output | 1 | Single-word write (write-around) |
| mem_addr | output | 32 | Lower-level byte address |
| mem_wdata | output | 256 | Block write data (word writes in low 32 bits) |
| mem_ack | input | 1 | Lower-level acknowledge, one cycle |
| mem_rdata | input | 256 | Fill data, valid with `mem_ack` |

## Verification
A single miss can trigger a victim write-back and a block fill for the new block in back-to-back transactions. The acknowledge of the first and the raising of the second then share a clock edge. This is provoked by dirtying a line and then touching a block with a different tag that maps to the same index, both in directed cases and in a pseudo-random mix over a few tags per index. The reference model judges the pair by the captured victim address and data, the fill address, the transaction order and the data returned afterwards.

// File: rtl/wbcache.sv
module wbcache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int CNT_W = 16,
  localparam int BLK_W = BLOCK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_on_wmiss,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BLK_W-1:0]  mem_rdata
);
  localparam int OFF_W  = $clog2(BLOCK_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BSEL_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = OFF_W - BSEL_W;

  typedef enum logic [2:0] {S_IDLE, S_WBACK, S_FILL, S_WARD, S_RESP} st_t;

  st_t               state;
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [BLK_W-1:0]  data_q [LINES];
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              req_we;
  logic              rsp_hit;
  logic [DATA_W-1:0] rsp_data;
  logic [BLK_W-1:0]  fill_line;

  wire [IDX_W-1:0]  cur_idx  = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  cur_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [WOFF_W-1:0] cur_woff = cpu_addr[BSEL_W +: WOFF_W];
  wire [IDX_W-1:0]  r_idx    = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  r_tag    = req_addr[ADDR_W-1 -: TAG_W];
  wire [WOFF_W-1:0] r_woff   = req_addr[BSEL_W +: WOFF_W];

  wire lookup_hit = valid_q[cur_idx] && (tag_q[cur_idx] == cur_tag);
  wire accept     = (state == S_IDLE) && cpu_req;
  wire fill_done  = (state == S_FILL) && mem_ack;

  assign cpu_ready = (state == S_RESP);
  assign cpu_hit   = rsp_hit;
  assign cpu_rdata = rsp_data;
  assign mem_req   = (state == S_WBACK) || (state == S_FILL) || (state == S_WARD);
  assign mem_we    = (state == S_WBACK) || (state == S_WARD);
  assign mem_word  = (state == S_WARD);

  always_comb begin
    case (state)
      S_WBACK: mem_addr = {tag_q[r_idx], r_idx, {OFF_W{1'b0}}};
      S_WARD:  mem_addr = req_addr;
      default: mem_addr = {r_tag, r_idx, {OFF_W{1'b0}}};
    endcase
    mem_wdata = (state == S_WARD) ? {{(BLK_W-DATA_W){1'b0}}, req_wdata} : data_q[r_idx];
    fill_line = mem_rdata;
    if (req_we) fill_line[r_woff*DATA_W +: DATA_W] = req_wdata;
  end

  always_ff @(posedge clk) begin
    if (accept && lookup_hit && cpu_we)
      data_q[cur_idx][cur_woff*DATA_W +: DATA_W] <= cpu_wdata;
    if (fill_done) begin
      data_q[r_idx] <= fill_line;
      tag_q[r_idx]  <= r_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      valid_q    <= '0;
      dirty_q    <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      req_addr   <= '0;
      req_wdata  <= '0;
      req_we     <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_data   <= '0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req) begin
          req_addr  <= cpu_addr;
          req_we    <= cpu_we;
          req_wdata <= cpu_wdata;
          rsp_hit   <= lookup_hit;
          if (lookup_hit) begin
            hit_count <= hit_count + 1'b1;
            rsp_data  <= cpu_we ? cpu_wdata : data_q[cur_idx][cur_woff*DATA_W +: DATA_W];
            if (cpu_we) dirty_q[cur_idx] <= 1'b1;
            state <= S_RESP;
          end else begin
            miss_count <= miss_count + 1'b1;
            if (cpu_we && !alloc_on_wmiss)                   state <= S_WARD;
            else if (valid_q[cur_idx] && dirty_q[cur_idx])   state <= S_WBACK;
            else                                             state <= S_FILL;
          end
        end
        S_WBACK: if (mem_ack) state <= S_FILL;
        S_FILL: if (mem_ack) begin
          valid_q[r_idx] <= 1'b1;
          dirty_q[r_idx] <= req_we;
          rsp_data       <= fill_line[r_woff*DATA_W +: DATA_W];
          state          <= S_RESP;
        end
        S_WARD: if (mem_ack) begin
          rsp_data <= req_wdata;
          state    <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbcache_chk.sv
module wbcache_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_on_wmiss,
  input logic              cpu_ready,
  input logic              cpu_hit,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_word,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_word));

  a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we && !mem_word |=> mem_req && !mem_we);

  a_r4_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_hit |-> $past(!mem_req));

  a_r9_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (miss_count == $past(miss_count)));

  a_r8_word_only_noalloc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_word |-> !alloc_on_wmiss && mem_we);
endmodule

bind wbcache wbcache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .alloc_on_wmiss(alloc_on_wmiss),
  .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
  .hit_count(hit_count), .miss_count(miss_count),
  .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
  .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/wbcache_test.sv
module wbcache_test;
  localparam int LINES = 32;
  localparam int BLK_W = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, alloc = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic cpu_ready, cpu_hit;
  logic [31:0] cpu_rdata;
  logic [15:0] hit_count, miss_count;
  logic mem_req, mem_we, mem_word;
  logic [31:0] mem_addr;
  logic [BLK_W-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [BLK_W-1:0] mem_rdata = '0;

  wbcache uut (
    .clk(clk), .rst_n(rst_n), .alloc_on_wmiss(alloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .hit_count(hit_count), .miss_count(miss_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(bit ok, string rq, string what, logic [BLK_W-1:0] act, logic [BLK_W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // lower-level memory
  logic [31:0] mstore [logic [31:0]];

  function automatic logic [31:0] mword(logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    if (mstore.exists(w)) return mstore[w];
    return w ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [BLK_W-1:0] blk_read(logic [31:0] base);
    logic [BLK_W-1:0] b;
    for (int w = 0; w < 8; w++) b[w*32 +: 32] = mword(base + 32'(w*4));
    return b;
  endfunction

  int lat = 0, n_wb = 0, n_fill = 0, n_ward = 0;
  logic [31:0] wb_addr, fill_addr, ward_addr, ward_data, hold_addr;
  logic [BLK_W-1:0] wb_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (lat == 0) hold_addr = mem_addr;
      else check(mem_addr == hold_addr, "R10", "mem_addr held", mem_addr, hold_addr);
      lat++;
      if (lat >= 2 + (n_wb + n_fill) % 3) begin
        lat = 0;
        mem_ack = 1'b1;
        if (mem_we && mem_word) begin
          n_ward++; ward_addr = mem_addr; ward_data = mem_wdata[31:0];
          mstore[{mem_addr[31:2], 2'b00}] = mem_wdata[31:0];
        end else if (mem_we) begin
          n_wb++; wb_addr = mem_addr; wb_data = mem_wdata;
          for (int w = 0; w < 8; w++) mstore[mem_addr + 32'(w*4)] = mem_wdata[w*32 +: 32];
        end else begin
          n_fill++; fill_addr = mem_addr; mem_rdata = blk_read(mem_addr);
        end
      end
    end
  end

  // reference model
  bit rv [LINES];
  bit rd [LINES];
  logic [21:0] rt [LINES];
  logic [BLK_W-1:0] rdat [LINES];
  int exp_hits = 0, exp_miss = 0;
  bit busy = 0;

  always @(negedge clk)
    if (rst_n && !busy) check(!cpu_ready && !mem_req, "R10", "quiet while idle", {cpu_ready, mem_req}, 0);

  task automatic model_reset();
    for (int i = 0; i < LINES; i++) begin rv[i] = 0; rd[i] = 0; end
    exp_hits = 0; exp_miss = 0;
  endtask

  task automatic do_reset(bit a);
    rst_n = 1'b0; alloc = a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check(hit_count == 0 && miss_count == 0, "R1", "counters", {hit_count, miss_count}, 0);
    check(!cpu_ready && !mem_req, "R1", "ready/mem_req", {cpu_ready, mem_req}, 0);
  endtask

  task automatic do_req(bit we, logic [31:0] a, logic [31:0] d);
    logic [4:0] idx = a[9:5];
    logic [21:0] tg = a[31:10];
    logic [2:0] wo = a[4:2];
    logic [31:0] base = {a[31:5], 5'b0};
    bit hit = rv[idx] && rt[idx] == tg;
    bit efill = !hit && (!we || alloc);
    bit eward = !hit && we && !alloc;
    bit ewb = efill && rv[idx] && rd[idx];
    logic [31:0] vbase = {rt[idx], idx, 5'b0};
    logic [BLK_W-1:0] vdata = rdat[idx];
    logic [BLK_W-1:0] nb;
    logic [31:0] erd;
    int b_wb = n_wb, b_fill = n_fill, b_ward = n_ward, cyc = 0;
    nb = efill ? blk_read(base) : rdat[idx];
    erd = nb[wo*32 +: 32];
    busy = 1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do begin @(negedge clk); cyc++; end while (!cpu_ready && cyc < 200);
    cpu_req = 1'b0;
    check(cpu_ready, "R10", "ready seen", cyc, 0);
    check(cpu_hit == hit, "R3", "hit flag", cpu_hit, hit);
    if (hit) check(cyc == 1, "R3", "hit latency", cyc, 1);
    if (hit && we) check(n_wb == b_wb && n_fill == b_fill && n_ward == b_ward, "R4", "no mem traffic", n_wb + n_fill + n_ward, b_wb + b_fill + b_ward);
    check(n_wb - b_wb == int'(ewb), "R5", "writeback count", n_wb - b_wb, ewb);
    if (ewb) begin
      check(wb_addr == vbase, "R5", "victim addr", wb_addr, vbase);
      check(wb_data == vdata, "R5", "victim data", wb_data, vdata);
    end
    check(n_fill - b_fill == int'(efill), "R6", "fill count", n_fill - b_fill, efill);
    if (efill) check(fill_addr == base, "R6", "fill addr", fill_addr, base);
    check(n_ward - b_ward == int'(eward), "R8", "word write count", n_ward - b_ward, eward);
    if (eward) begin
      check(ward_addr == a, "R8", "word write addr", ward_addr, a);
      check(ward_data == d, "R8", "word write data", ward_data, d);
    end
    if (!we) check(cpu_rdata == erd, hit ? "R3" : "R6", "read data", cpu_rdata, erd);
    if (hit) exp_hits++; else exp_miss++;
    check(hit_count == 16'(exp_hits) && miss_count == 16'(exp_miss), "R9", "counters",
          {hit_count, miss_count}, {16'(exp_hits), 16'(exp_miss)});
    if (hit || efill) begin
      if (we) begin nb[wo*32 +: 32] = d; rd[idx] = 1; end
      else if (!hit) rd[idx] = 0;
      if (efill && !we) rd[idx] = 0;
      rdat[idx] = nb; rt[idx] = tg; rv[idx] = 1;
    end
    @(negedge clk);
    busy = 0;
    check(!cpu_ready, "R10", "ready single pulse", cpu_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1234_567;
    model_reset();
    do_reset(1'b1);

    // R11 with allocation; R7 write misses allocate
    do_req(1, 32'd100, 32'hAAAA_0001);
    do_req(0, 32'd200, 0);
    do_req(1, 32'd200, 32'hAAAA_0002);
    do_req(1, 32'd100, 32'hAAAA_0003);
    check(hit_count == 2 && miss_count == 2, "R11", "allocate counts", {hit_count, miss_count}, {16'd2, 16'd2});
    do_req(0, 32'd100, 0); // R7 merged word read back

    // R5 dirty victim then clean victim, R2 index/tag split
    do_req(0, 32'd100 + 32'd1024, 0);
    do_req(0, 32'd100 + 32'd2048, 0);
    do_req(0, 32'd96, 0);
    do_req(0, 32'h1234_5660, 0);
    do_req(0, 32'h1234_567C, 0);
    do_req(0, 32'h1234_5A60, 0);

    // R11 without allocation; R8 write-around leaves cache alone
    do_reset(1'b0);
    do_req(1, 32'd100, 32'hBBBB_0001);
    do_req(0, 32'd200, 0);
    do_req(1, 32'd200, 32'hBBBB_0002);
    do_req(1, 32'd100, 32'hBBBB_0003);
    check(hit_count == 1 && miss_count == 3, "R11", "no-allocate counts", {hit_count, miss_count}, {16'd1, 16'd3});
    do_req(0, 32'd100, 0);

    for (int ph = 0; ph < 2; ph++) begin
      do_reset(ph == 0);
      for (int k = 0; k < 200; k++) begin
        logic [31:0] a;
        seed = seed * 1103515245 + 12345;
        a = {20'(seed[30:29]), 2'b00, 5'(seed[27:26]), seed[24:22], 2'b00};
        do_req(seed[20], a, 32'(seed) ^ 32'(k));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule